// File: doc/BRIEF.md
# Synchronized Measurement Window Controller

This block produces the count-enable window for a reciprocal-free frequency meter. A gate counter and an event counter sit outside the block. Before a reading, the controller loads the gate counter with a negative value and clears the event counter. It then raises `start_i`. The block opens `window_o` on the next rising edge of the reference clock. `window_o` drives the count enables of both counters, so both counters run over exactly the same span of reference edges.

The gate counter signals that it is close to terminal count through `near_end_i`. This indicator turns active when the top 16 bits of the 24-bit gate counter are all ones, which is 256 counts before the counter wraps. On the first reference edge that samples this indicator active while the window is open, the block closes the window. The preset is therefore the negative of the window length, further lowered by 255 to make up for the early indicator. For example, −(10,000,000 + 255) gives a window of exactly ten million reference cycles.

The window comes from two flip-flops: an arm flop and a hold flop. Lowering `start_i` returns both flops to their idle values and re-arms the block. `done_o` reports that a window has closed and stays high until `start_i` is lowered.

Top module: `gate_window_ctl`

## Requirements
- R1: While `rst_ni` is low, `window_o` and `done_o` are 0.
- R2: A rising edge that samples `start_i` low leaves `window_o` and `done_o` at 0, whatever `near_end_i` is.
- R3: From the idle state, the first rising edge that samples `start_i` high, with `near_end_i` inactive, drives `window_o` to 1.
- R4: While `start_i` stays high, `window_o` stays 1 across every edge that samples `near_end_i` inactive. It falls on the first edge that samples `near_end_i` active. With the default polarity, active means `near_end_i` is low.
- R5: Suppose an up-counting 24-bit gate counter is enabled by `window_o` and preset to −(N+255) mod 2^24, with `near_end_i` low whenever its bits 23..8 are all ones. Then for N ≥ 2, `window_o` is high for exactly N reference cycles.
- R6: `done_o` rises on the edge where the window closes and stays 1 while `start_i` stays high.
- R7: After a window has closed, the first edge that samples `start_i` low returns `done_o` to 0. A later rise of `start_i` opens a new window.
- R8: While `done_o` is 1, `window_o` stays 0, even if `near_end_i` becomes inactive again.
- R9: If `near_end_i` is already active on the edge that first samples `start_i` high, `window_o` never rises and `done_o` becomes 1 on that edge.
- R10: If `start_i` is sampled low while the window is open, `window_o` falls on that edge and `done_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock; all state changes on its rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Measurement request, synchronous to `clk_i`; low re-arms the block |
| near_end_i | input | 1 | Early terminal indicator from the gate counter (active low by default) |
| window_o | output | 1 | Count enable for the gate and event counters |
| done_o | output | 1 | Window has closed; held until `start_i` is lowered |

## Verification
The bench surrounds the block with a model of the 24-bit gate counter. It measures window lengths for random presets and for the shortest legal length of two cycles, so an off-by-one at either the opening or the closing edge shows up as a length mismatch. Presets of N = 1 and N = 0 put the indicator already active at start. These cases separate a design that checks the indicator immediately from one that opens for a cycle first. An abort in mid-window separates a clean return to idle from a false `done_o`. Forcing the indicator inactive after completion tells a sticky hold flop from one that would reopen the window.

// File: rtl/gate_pkg.sv
package gate_pkg;

    // Polarity of the early terminal indicator from the gate counter
    typedef enum logic {
        NEAR_ACT_LOW  = 1'b0,
        NEAR_ACT_HIGH = 1'b1
    } near_pol_e;

    typedef struct packed {
        logic armed;
    } arm_regs_t;

    typedef struct packed {
        logic hold;
    } hold_regs_t;

    // Reset / idle values of the two window flops
    localparam logic ARM_IDLE  = 1'b0;
    localparam logic HOLD_IDLE = 1'b1;

endpackage

// File: rtl/gate_arm_ff.sv
// Opening flop: sets on the first edge with start high while the hold flop
// is still set; cleared whenever start is low.
module gate_arm_ff
    import gate_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic start_i,
    input  logic hold_i,
    output logic armed_o
);

    arm_regs_t q, d;

    always_comb begin
        d = q;
        if (!start_i) begin
            d.armed = ARM_IDLE;
        end else begin
            d.armed = q.armed | hold_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q.armed <= ARM_IDLE;
        end else begin
            q <= d;
        end
    end

    assign armed_o = q.armed;

endmodule

// File: rtl/gate_hold_ff.sv
// Closing flop: preset while start is low; once start is high it clears on
// the first edge that samples the early terminal indicator active, and stays
// cleared until start drops.
module gate_hold_ff
    import gate_pkg::*;
#(
    parameter near_pol_e POL = NEAR_ACT_LOW
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic start_i,
    input  logic near_end_i,
    output logic hold_o
);

    hold_regs_t q, d;
    logic       near_act;

    generate
        if (POL == NEAR_ACT_LOW) begin : g_act_low
            assign near_act = ~near_end_i;
        end else begin : g_act_high
            assign near_act = near_end_i;
        end
    endgenerate

    always_comb begin
        d = q;
        if (!start_i) begin
            d.hold = HOLD_IDLE;
        end else begin
            d.hold = q.hold & ~near_act;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q.hold <= HOLD_IDLE;
        end else begin
            q <= d;
        end
    end

    assign hold_o = q.hold;

endmodule

// File: rtl/gate_window_ctl.sv
module gate_window_ctl
    import gate_pkg::*;
#(
    parameter near_pol_e NEAR_END_POL = NEAR_ACT_LOW
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic start_i,
    input  logic near_end_i,
    output logic window_o,
    output logic done_o
);

    logic armed_q;
    logic hold_q;

    gate_arm_ff u_arm (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .start_i (start_i),
        .hold_i  (hold_q),
        .armed_o (armed_q)
    );

    gate_hold_ff #(
        .POL (NEAR_END_POL)
    ) u_hold (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .start_i    (start_i),
        .near_end_i (near_end_i),
        .hold_o     (hold_q)
    );

    // Both outputs are gates of flop outputs only: they change on clock edges
    always_comb begin
        window_o = armed_q & hold_q;
        done_o   = armed_q & ~hold_q;
    end

endmodule

// File: rtl/gate_window_chk.sv
module gate_window_chk
    import gate_pkg::*;
#(
    parameter near_pol_e POL = NEAR_ACT_LOW
) (
    input logic clk_i,
    input logic rst_ni,
    input logic start_i,
    input logic near_end_i,
    input logic window_o,
    input logic done_o
);

    logic near_act;
    assign near_act = (POL == NEAR_ACT_LOW) ? !near_end_i : near_end_i;

    // R1
    always_comb begin
        if (!rst_ni) begin
            reset_quiet_chk: assert (!window_o && !done_o);
        end
    end

    // R2
    idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !start_i |=> (!window_o && !done_o));

    // R3
    open_on_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (start_i && !window_o && !done_o && !near_act) |=> window_o);

    // R4
    stay_open_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (start_i && window_o && !near_act) |=> window_o);

    // R4
    close_on_near_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (start_i && window_o && near_act) |=> (!window_o && done_o));

    // R6
    done_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (start_i && done_o) |=> done_o);

    // R8
    done_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> !window_o);

    // R9
    early_near_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (start_i && !window_o && !done_o && near_act) |=> (!window_o && done_o));

    // R10
    abort_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!start_i && window_o) |=> (!window_o && !done_o));

endmodule

bind gate_window_ctl gate_window_chk #(
    .POL (NEAR_END_POL)
) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .near_end_i (near_end_i),
    .window_o   (window_o),
    .done_o     (done_o)
);

// File: tb/sim_gate_window_ctl.sv
module sim_gate_window_ctl;

    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 24;
    localparam int WATCHDOG   = 200000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic near_end;
    logic window, done;
    logic [CNT_W-1:0] gate_cnt = '0;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gate_window_ctl u0 (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .start_i    (start),
        .near_end_i (near_end),
        .window_o   (window),
        .done_o     (done)
    );

    // Gate counter model: counts up while enabled; indicator low when the
    // upper 16 bits are all ones
    always @(posedge clk) begin
        if (window) gate_cnt <= gate_cnt + 1'b1;
    end
    assign near_end = ~(&gate_cnt[CNT_W-1:8]);

    function automatic logic [CNT_W-1:0] preset_for(int n);
        return CNT_W'((1 << CNT_W) - n - 255);
    endfunction

    function automatic int expect_len(int n);
        return (n >= 2) ? n : 0;
    endfunction

    task automatic check(string req, int actual, int expected);
        checks++;
        if (actual != expected) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        finished = 1;
        $finish;
    endtask

    // One full measurement with window length n
    task automatic run_window(int n);
        int len = 0;
        int guard = 0;
        @(negedge clk);
        gate_cnt = preset_for(n);
        start = 1'b1;
        @(negedge clk);
        if (n >= 2) check("R3 open", int'(window), 1);
        else begin
            check("R9 window", int'(window), 0);
            check("R9 done", int'(done), 1);
        end
        while (window && guard < 100000) begin
            len++;
            guard++;
            @(negedge clk);
        end
        check("R5 length", len, expect_len(n));
        check("R6 done at close", int'(done), 1);
        repeat (3) @(negedge clk);
        check("R6 done held", int'(done), 1);
        gate_cnt = '0;               // indicator inactive again
        repeat (3) @(negedge clk);
        check("R8 no reopen", int'(window), 0);
        start = 1'b0;
        @(negedge clk);
        check("R7 done clear", int'(done), 0);
        check("R7 window idle", int'(window), 0);
    endtask

    initial begin
        void'($urandom(32'd4711));
        #1;
        check("R1 window", int'(window), 0);
        check("R1 done", int'(done), 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R2: indicator toggling while idle has no effect
        gate_cnt = 24'hFFFF80;
        repeat (3) @(negedge clk);
        check("R2 window", int'(window), 0);
        check("R2 done", int'(done), 0);
        gate_cnt = '0;
        @(negedge clk);
        check("R2 idle", int'(window) + int'(done), 0);

        // Directed corners
        run_window(2);
        run_window(3);
        run_window(1);               // R9
        run_window(0);               // R9
        run_window(256);
        run_window(257);

        // R10: abort mid-window
        @(negedge clk);
        gate_cnt = preset_for(500);
        start = 1'b1;
        repeat (100) @(negedge clk);
        check("R10 open", int'(window), 1);
        start = 1'b0;
        @(negedge clk);
        check("R10 window", int'(window), 0);
        check("R10 done", int'(done), 0);

        // R7: re-arm after abort and completion
        run_window(40);

        // Random lengths
        for (int i = 0; i < 20; i++) begin
            run_window(2 + int'($urandom % 1500));
        end

        finish_run();
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

endmodule